// File: doc/BRIEF.md
# Frame Writeback Sequencer

This block is the control and status core of a display writeback engine. A small register port holds a destination base pointer, an optional 8-bit upper pointer, a line pitch, a packed frame size and a control word. Software writes the control word with the start bit set. This launches a frame. The sequencer then counts scanlines as the memory side reports each one committed. It exposes the running count and drops its busy flag once the programmed height is reached. If the idle interrupt was enabled for that frame, it then raises an interrupt. A frame can be cut short by an abort command. The internal memory can be placed in a powered-down state while the engine is idle.

The states are OFF (powered down), IDLE and RUN. The transitions are:
- IDLE to RUN on an accepted start.
- RUN to IDLE on the last line or on an abort.
- IDLE to OFF when the powerdown bit is set.
- OFF to IDLE when the powerdown bit is cleared.

A parameter selects whether the size fields hold the count itself or the count minus one. Memory traffic is not part of the block: `line_done` is a one-cycle pulse per committed line. `busy` doubles as the permit for memory writes.

Top module: `wbk_seq`

## Requirements
- R1: A control write (byte offset 0x0C) with bit 0 set, made while in IDLE and not also setting bit 21, moves the block to RUN: `busy` is high and the progress register reads 0 after that edge. Bit 0 always reads back 0.
- R2: A start written while in RUN or OFF is ignored: the state and the progress count are unchanged by it.
- R3: In RUN, each `line_done` pulse increments the progress count, which reads at offset 0x10.
- R4: The frame size register at 0x08 holds the width in bits 15:0 and the height in bits 31:16. In the default mode a field is the count itself, and a height of 0 counts as 1. With SIZE_M1=1 each field is the count minus one. `frm_width` presents the decoded width.
- R5: The block leaves RUN for IDLE on the very edge at which the progress count reaches the decoded height.
- R6: A control write with bit 14 set, made in RUN, moves the block to IDLE at that edge. A `line_done` pulse in that same cycle is not counted. Bit 14 reads back 0.
- R7: `irq` rises at the edge where a frame ends, by completion or by abort, provided that the enable bit 2 is set. The value of bit 2 used here is the one in effect after that cycle's writes. `irq` falls after any control write with bit 2 clear, or after an accepted start.
- R8: Control reads return 0x54 in bits 31:24 and 0b01 in bits 23:22, whatever is written there. Bit 1 is `busy`. Bits 21:2 other than 14 return what was last written.
- R9: Setting control bit 21 in IDLE raises `mem_pd` at the next edge, and clearing it returns the block to IDLE. A frame in progress is not affected; the block powers down on the edge after that frame ends.
- R10: `dst_addr` is {upper pointer at 0x14 bits 7:0, pointer at 0x00}, and `dst_pitch` is the register at 0x04. Each of these reads back. With HAS_HI=0 the upper pointer reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | AW (5) | Register byte offset |
| cfg_wdata | input | DW (32) | Register write data |
| cfg_rdata | output | DW (32) | Read data for `cfg_addr` (combinational) |
| line_done | input | 1 | One line committed to memory |
| busy | output | 1 | Frame in progress / memory write permit |
| irq | output | 1 | Idle interrupt |
| mem_pd | output | 1 | Internal memory powered down |
| dst_addr | output | DW+HI_W (40) | Destination base address |
| dst_pitch | output | DW (32) | Line pitch |
| frm_width | output | DW/2+1 (17) | Decoded frame width |

## Verification
The pairings that matter are frame end and control write landing in the same cycle. One case is the last `line_done` pulse coinciding with a write that clears or sets the interrupt enable; the enable written in that cycle must decide whether `irq` rises. The other is an abort arriving with a `line_done` pulse, where the abort wins and the count stays frozen. The bench provokes both directly and with random traffic, on two instances that differ in size mode and upper-pointer support. A behavioural model predicts each output every cycle and judges them.

// File: rtl/wbk_pkg.sv
package wbk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_OFF  = 2'd2
    } wbk_state_e;

    localparam logic [4:0] OFS_PTR   = 5'h00;
    localparam logic [4:0] OFS_PITCH = 5'h04;
    localparam logic [4:0] OFS_DIM   = 5'h08;
    localparam logic [4:0] OFS_CTRL  = 5'h0C;
    localparam logic [4:0] OFS_PROG  = 5'h10;
    localparam logic [4:0] OFS_PTRHI = 5'h14;

    localparam int B_GO    = 0;
    localparam int B_IE    = 2;
    localparam int B_ABORT = 14;
    localparam int B_PD    = 21;

    localparam logic [7:0] CTRL_TAG = 8'h54;
    localparam logic [1:0] CTRL_REV = 2'b01;
endpackage

// File: rtl/wbk_regs.sv
module wbk_regs
    import wbk_pkg::*;
#(
    parameter int DW      = 32,
    parameter int AW      = 5,
    parameter int HI_W    = 8,
    parameter bit HAS_HI  = 1'b1,
    parameter bit SIZE_M1 = 1'b0,
    parameter int FLD_W   = DW / 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [AW-1:0]      addr,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      ptr_q,
    output logic [DW-1:0]      pitch_q,
    output logic [DW-1:0]      dim_q,
    output logic [B_PD:B_IE]   ctrl_q,
    output logic [HI_W-1:0]    hi_q,
    output logic [FLD_W:0]     width_cnt,
    output logic [FLD_W:0]     height_cnt,
    output logic               go_req,
    output logic               abort_req,
    output logic               ie_next,
    output logic               pd_next
);
    logic              ctrl_hit;
    logic [B_PD:B_IE]  ctrl_keep;
    logic [FLD_W-1:0]  w_fld;
    logic [FLD_W-1:0]  h_fld;

    assign ctrl_hit  = we && (addr == OFS_CTRL);
    assign go_req    = ctrl_hit && wdata[B_GO];
    assign abort_req = ctrl_hit && wdata[B_ABORT];
    assign ie_next   = ctrl_hit ? wdata[B_IE] : ctrl_q[B_IE];
    assign pd_next   = ctrl_hit ? wdata[B_PD] : ctrl_q[B_PD];

    always_comb begin
        ctrl_keep          = wdata[B_PD:B_IE];
        ctrl_keep[B_ABORT] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            pitch_q <= '0;
            dim_q   <= '0;
            ctrl_q  <= '0;
        end else if (we) begin
            if (addr == OFS_PTR)   ptr_q   <= wdata;
            if (addr == OFS_PITCH) pitch_q <= wdata;
            if (addr == OFS_DIM)   dim_q   <= wdata;
            if (addr == OFS_CTRL)  ctrl_q  <= ctrl_keep;
        end
    end

    generate
        if (HAS_HI) begin : g_hi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                          hi_q <= '0;
                else if (we && addr == OFS_PTRHI)    hi_q <= wdata[HI_W-1:0];
            end
        end else begin : g_no_hi
            assign hi_q = '0;
        end
    endgenerate

    assign w_fld = dim_q[FLD_W-1:0];
    assign h_fld = dim_q[DW-1:FLD_W];

    generate
        if (SIZE_M1) begin : g_minus_one
            assign width_cnt  = {1'b0, w_fld} + (FLD_W+1)'(1);
            assign height_cnt = {1'b0, h_fld} + (FLD_W+1)'(1);
        end else begin : g_plain
            assign width_cnt  = {1'b0, w_fld};
            assign height_cnt = (h_fld == '0) ? (FLD_W+1)'(1) : {1'b0, h_fld};
        end
    endgenerate
endmodule

// File: rtl/wbk_fsm.sv
module wbk_fsm
    import wbk_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go_req,
    input  logic           abort_req,
    input  logic           ie_next,
    input  logic           pd_next,
    input  logic           line_done,
    input  logic [CNT_W:0] height_cnt,
    output logic           busy,
    output logic           mem_pd,
    output logic           irq,
    output logic [CNT_W:0] progress
);
    wbk_state_e     state_q, state_d;
    logic [CNT_W:0] prog_q;
    logic [CNT_W:0] tgt_q;
    logic           pend_q;
    logic           go_ok, abort_hit, count_en, last_line, frame_end;

    assign go_ok     = (state_q == ST_IDLE) && go_req && !pd_next;
    assign abort_hit = (state_q == ST_RUN) && abort_req;
    assign count_en  = (state_q == ST_RUN) && line_done && !abort_req;
    assign last_line = count_en && ((prog_q + 1'b1) == tgt_q);
    assign frame_end = last_line || abort_hit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go_ok)        state_d = ST_RUN;
                else if (pd_next) state_d = ST_OFF;
            end
            ST_RUN: begin
                if (frame_end)    state_d = ST_IDLE;
            end
            ST_OFF: begin
                if (!pd_next)     state_d = ST_IDLE;
            end
            default:              state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_q <= '0;
            tgt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (go_ok) begin
                prog_q <= '0;
                tgt_q  <= height_cnt;
            end else if (count_en) begin
                prog_q <= prog_q + 1'b1;
            end
            pend_q <= go_ok ? 1'b0 : ((pend_q || frame_end) && ie_next);
        end
    end

    assign busy     = (state_q == ST_RUN);
    assign mem_pd   = (state_q == ST_OFF);
    assign irq      = pend_q;
    assign progress = prog_q;

    AST_GO_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && go_req && !pd_next) |=> (busy && progress == '0)); // R1
    AST_GO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && go_req && !abort_req && !line_done) |=> (busy && $stable(progress))); // R2
    AST_PROG_BELOW_TGT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (progress < tgt_q)); // R5
    AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && abort_req) |=> (!busy && $stable(progress))); // R6
    AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !busy); // R7
    AST_PD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_pd |-> !busy); // R9
endmodule

// File: rtl/wbk_seq.sv
module wbk_seq
    import wbk_pkg::*;
#(
    parameter int DW      = 32,
    parameter int AW      = 5,
    parameter int HI_W    = 8,
    parameter bit HAS_HI  = 1'b1,
    parameter bit SIZE_M1 = 1'b0,
    localparam int FLD_W  = DW / 2,
    localparam int OUT_AW = DW + HI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [DW-1:0]     cfg_wdata,
    output logic [DW-1:0]     cfg_rdata,
    input  logic              line_done,
    output logic              busy,
    output logic              irq,
    output logic              mem_pd,
    output logic [OUT_AW-1:0] dst_addr,
    output logic [DW-1:0]     dst_pitch,
    output logic [FLD_W:0]    frm_width
);
    logic [DW-1:0]     ptr_q, pitch_q, dim_q;
    logic [B_PD:B_IE]  ctrl_q;
    logic [HI_W-1:0]   hi_q;
    logic [FLD_W:0]    height_cnt;
    logic [FLD_W:0]    progress;
    logic              go_req, abort_req, ie_next, pd_next;

    wbk_regs #(
        .DW(DW), .AW(AW), .HI_W(HI_W), .HAS_HI(HAS_HI), .SIZE_M1(SIZE_M1), .FLD_W(FLD_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .ptr_q(ptr_q), .pitch_q(pitch_q), .dim_q(dim_q), .ctrl_q(ctrl_q), .hi_q(hi_q),
        .width_cnt(frm_width), .height_cnt(height_cnt),
        .go_req(go_req), .abort_req(abort_req), .ie_next(ie_next), .pd_next(pd_next)
    );

    wbk_fsm #(.CNT_W(FLD_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .go_req(go_req), .abort_req(abort_req),
        .ie_next(ie_next), .pd_next(pd_next), .line_done(line_done),
        .height_cnt(height_cnt), .busy(busy), .mem_pd(mem_pd), .irq(irq),
        .progress(progress)
    );

    always_comb begin
        case (cfg_addr)
            OFS_PTR:   cfg_rdata = ptr_q;
            OFS_PITCH: cfg_rdata = pitch_q;
            OFS_DIM:   cfg_rdata = dim_q;
            OFS_CTRL:  cfg_rdata = {CTRL_TAG, CTRL_REV, ctrl_q, busy, 1'b0};
            OFS_PROG:  cfg_rdata = DW'(progress);
            OFS_PTRHI: cfg_rdata = DW'(hi_q);
            default:   cfg_rdata = '0;
        endcase
    end

    assign dst_addr  = {hi_q, ptr_q};
    assign dst_pitch = pitch_q;

    AST_RD_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == OFS_CTRL) |-> (cfg_rdata[31:22] == {CTRL_TAG, CTRL_REV} && !cfg_rdata[B_GO] && !cfg_rdata[B_ABORT])); // R8
endmodule

// File: tb/test_wbk_seq.sv
module test_wbk_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = 5'h0;
    logic [31:0] cfg_wdata = 32'h0;
    logic        line_done = 1'b0;

    logic [31:0] rd [2];
    logic        bsy [2], irq_o [2], pd_o [2];
    logic [39:0] da [2];
    logic [31:0] dp [2];
    logic [16:0] fw [2];

    int checks = 0;
    int fails = 0;
    bit fin = 1'b0;

    always #5 clk = ~clk;

    wbk_seq i_wbk_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(rd[0]), .line_done(line_done), .busy(bsy[0]), .irq(irq_o[0]),
        .mem_pd(pd_o[0]), .dst_addr(da[0]), .dst_pitch(dp[0]), .frm_width(fw[0])
    );

    wbk_seq #(.HAS_HI(1'b0), .SIZE_M1(1'b1)) i_wbk_seq_m1 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(rd[1]), .line_done(line_done), .busy(bsy[1]), .irq(irq_o[1]),
        .mem_pd(pd_o[1]), .dst_addr(da[1]), .dst_pitch(dp[1]), .frm_width(fw[1])
    );

    // behavioural reference: st 0=idle 1=run 2=off
    int          st [2] = '{0, 0};
    int          prog [2] = '{0, 0};
    int          tgt [2] = '{0, 0};
    bit          mirq [2] = '{0, 0};
    logic [31:0] m_ptr [2] = '{0, 0};
    logic [31:0] m_pitch [2] = '{0, 0};
    logic [31:0] m_dim [2] = '{0, 0};
    logic [7:0]  m_hi [2] = '{0, 0};
    logic [21:2] m_ctrl [2] = '{0, 0};

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 2; k++) begin
                st[k] = 0; prog[k] = 0; tgt[k] = 0; mirq[k] = 0;
                m_ptr[k] = 0; m_pitch[k] = 0; m_dim[k] = 0; m_hi[k] = 0; m_ctrl[k] = 0;
            end
        end else begin
            for (int k = 0; k < 2; k++) begin
                bit cw, ie_n, pd_n, go_ok, fend;
                int h;
                cw    = cfg_we && cfg_addr == 5'h0C;
                ie_n  = cw ? cfg_wdata[2]  : m_ctrl[k][2];
                pd_n  = cw ? cfg_wdata[21] : m_ctrl[k][21];
                go_ok = 0;
                fend  = 0;
                h     = int'(m_dim[k][31:16]);
                if (st[k] == 0) begin
                    if (cw && cfg_wdata[0] && !pd_n) begin
                        go_ok = 1; st[k] = 1; prog[k] = 0;
                        tgt[k] = (k == 1) ? h + 1 : ((h == 0) ? 1 : h);
                    end else if (pd_n) st[k] = 2;
                end else if (st[k] == 1) begin
                    if (cw && cfg_wdata[14]) begin
                        st[k] = 0; fend = 1;
                    end else if (line_done) begin
                        prog[k]++;
                        if (prog[k] == tgt[k]) begin st[k] = 0; fend = 1; end
                    end
                end else if (!pd_n) st[k] = 0;
                mirq[k] = go_ok ? 1'b0 : ((mirq[k] || fend) && ie_n);
                if (cfg_we) begin
                    case (cfg_addr)
                        5'h00: m_ptr[k] = cfg_wdata;
                        5'h04: m_pitch[k] = cfg_wdata;
                        5'h08: m_dim[k] = cfg_wdata;
                        5'h0C: begin m_ctrl[k] = cfg_wdata[21:2]; m_ctrl[k][14] = 1'b0; end
                        5'h14: if (k == 0) m_hi[k] = cfg_wdata[7:0];
                        default: ;
                    endcase
                end
            end
        end
    end

    function automatic logic [31:0] exp_rd(int k, logic [4:0] a);
        case (a)
            5'h00: return m_ptr[k];
            5'h04: return m_pitch[k];
            5'h08: return m_dim[k];
            5'h0C: return {8'h54, 2'b01, m_ctrl[k], (st[k] == 1), 1'b0};
            5'h10: return 32'(prog[k]);
            5'h14: return {24'h0, m_hi[k]};
            default: return 32'h0;
        endcase
    endfunction

    task automatic cmp(string tag, int k, logic [39:0] act, logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s inst%0d t=%0t actual %h expected %h", tag, k, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!fin) begin
            for (int k = 0; k < 2; k++) begin
                logic [16:0] ew;
                string rtag;
                ew = (k == 1) ? {1'b0, m_dim[k][15:0]} + 17'd1 : {1'b0, m_dim[k][15:0]};
                case (cfg_addr)
                    5'h0C: rtag = "R8 R1 R6 ctrl read";
                    5'h10: rtag = "R3 progress read";
                    5'h08: rtag = "R4 size read";
                    default: rtag = "R10 reg read";
                endcase
                cmp("R1 R2 R5 R6 busy", k, 40'(bsy[k]), 40'(st[k] == 1));
                cmp("R7 irq", k, 40'(irq_o[k]), 40'(mirq[k]));
                cmp("R9 mem_pd", k, 40'(pd_o[k]), 40'(st[k] == 2));
                cmp("R10 dst_addr", k, da[k], {m_hi[k], m_ptr[k]});
                cmp("R10 dst_pitch", k, 40'(dp[k]), 40'(m_pitch[k]));
                cmp("R4 frm_width", k, 40'(fw[k]), 40'(ew));
                cmp(rtag, k, 40'(rd[k]), 40'(exp_rd(k, cfg_addr)));
            end
        end
    end

    task automatic cyc(bit we, logic [4:0] a, logic [31:0] d, bit ld);
        @(negedge clk);
        #1;
        cfg_we = we; cfg_addr = a; cfg_wdata = d; line_done = ld;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 5'(4 * (i % 6)), 32'h0, 0);
    endtask

    task automatic lines(int n);
        for (int i = 0; i < n; i++) begin
            cyc(0, 5'h10, 32'h0, 1);
            cyc(0, 5'h0C, 32'h0, 0);
        end
    endtask

    initial begin
        #2_000_000;
        if (!fin) begin
            fin = 1;
            fails++;
            $display("FAIL watchdog expired actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(3);                                   // reset state
        #1 rst_n = 1'b1;
        idle(2);
        // R10: pointer, pitch, upper pointer
        cyc(1, 5'h00, 32'h1234_5670, 0);
        cyc(1, 5'h04, 32'h0000_1000, 0);
        cyc(1, 5'h14, 32'hFFFF_FF5A, 0);
        cyc(1, 5'h08, {16'd3, 16'd640}, 0);        // R4
        idle(6);
        // R8: fixed fields ignore writes
        cyc(1, 5'h0C, 32'hFFC0_0000, 0);
        idle(2);
        // R1 R3 R5 R7: frame with interrupt
        cyc(1, 5'h0C, 32'h0000_0005, 0);
        lines(3);
        idle(3);
        cyc(1, 5'h0C, 32'h0000_0000, 0);           // acknowledge
        idle(2);
        // R2: start while running
        cyc(1, 5'h0C, 32'h0000_0001, 0);
        lines(1);
        cyc(1, 5'h0C, 32'h0000_0001, 0);
        idle(2);
        lines(3);
        // R6: abort with interrupt
        cyc(1, 5'h0C, 32'h0000_0005, 0);
        lines(1);
        cyc(1, 5'h0C, 32'h0000_4004, 0);
        lines(2);
        // R6: abort and line in the same cycle
        cyc(1, 5'h0C, 32'h0000_0001, 0);
        lines(1);
        cyc(1, 5'h0C, 32'h0000_4000, 1);
        idle(3);
        // R4: zero height
        cyc(1, 5'h08, {16'd0, 16'd7}, 0);
        cyc(1, 5'h0C, 32'h0000_0005, 0);
        lines(2);
        cyc(1, 5'h08, {16'd2, 16'd7}, 0);
        // R7: enable cleared on the last line cycle
        cyc(1, 5'h0C, 32'h0000_0005, 0);
        lines(2);
        cyc(1, 5'h0C, 32'h0000_0000, 1);
        cyc(1, 5'h0C, 32'h0000_0000, 1);
        idle(2);
        // R7: enable set on the last line cycle
        cyc(1, 5'h0C, 32'h0000_0001, 0);
        lines(2);
        cyc(1, 5'h0C, 32'h0000_0004, 1);
        cyc(1, 5'h0C, 32'h0000_0004, 1);
        idle(2);
        // R9: powerdown, start refused while off
        cyc(1, 5'h0C, 32'h0020_0000, 0);
        idle(2);
        cyc(1, 5'h0C, 32'h0020_0001, 0);
        idle(1);
        cyc(1, 5'h0C, 32'h0000_0001, 0);           // R2: leaves OFF, no start
        idle(2);
        // R9: powerdown requested mid-frame
        cyc(1, 5'h0C, 32'h0000_0001, 0);
        cyc(1, 5'h0C, 32'h0020_0000, 0);
        lines(4);
        idle(2);
        cyc(1, 5'h0C, 32'h0000_0000, 0);
        idle(2);
        // mixed traffic
        for (int i = 0; i < 3000; i++) begin
            logic [4:0]  a;
            logic [31:0] d;
            bit          we;
            a  = 5'(4 * ($urandom % 6));
            d  = $urandom;
            we = ($urandom % 10) < 3;
            if (a == 5'h08) d[31:16] = 16'($urandom % 6);
            if (a == 5'h0C) d[21] = ($urandom % 8) == 0;
            cyc(we, a, d, $urandom % 2 == 0);
        end
        idle(4);
        fin = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule